// File: doc/BRIEF.md
# Video Memory Access Decoder

This block sits between a processor bus and a byte-addressed video memory. It decodes each 32-bit bus address into one of several windows. The only window it serves itself is a linear window onto the memory. For that window it performs byte, halfword and word reads and writes in little-endian order. A multi-byte access that runs past the last byte continues at byte 0.

The planar window, the text window, the reserved window, the font/IO window and the font-ROM window are handled by other logic. For those, this block only reports which window was hit. Reads from them, and from any address outside every window, return all ones at the access width.

The block also keeps one dirty flag for each 8-byte block of memory. A write sets a block's flag only if that write really changes a stored byte in the block. A display fetch engine sees the whole flag vector and clears single flags through a dedicated port.

Top module: `vram_access_unit`

## Requirements
- R1: An address whose bits 31:20 equal 0x800 selects the linear window, reported as region code 1. The memory byte offset is the address bits below the memory size (offset = address minus 0x80000000, modulo the memory size).
- R2: When bits 31:20 are zero, bits 19:12 select a region as follows. Values 0xC0 to 0xC7 give code 2 (planar), 0xC8 gives 3 (text), 0xC9 gives 4 (reserved), 0xCA gives 5 (font/IO) and 0xCB gives 6 (font ROM). Every other address gives code 0 (unmapped).
- R3: A read from any region other than code 1 returns all ones at the access width, zero-extended to 32 bits: 0x000000FF, 0x0000FFFF or 0xFFFFFFFF.
- R4: Size code 0 is a byte access, 1 a halfword and 2 a word; code 3 acts as a word. The byte at the lowest offset occupies data bits 7:0. Narrow reads are zero-extended.
- R5: Byte i of a multi-byte access lives at offset (offset + i) modulo the memory size. A halfword at the last byte therefore pairs that byte (low) with byte 0 (high).
- R6: One cycle after a request is sampled, rsp_valid is 1 and rsp_region holds the region code. rsp_rdata holds the read data, or zero for a write.
- R7: A write to any region other than code 1 leaves the memory contents and the dirty flags unchanged.
- R8: A write stores a byte, and sets the dirty flag of that byte's block (offset shifted right by 3), only when the new byte differs from the stored one. Rewriting identical data sets no flag.
- R9: clr_valid clears the flag selected by clr_index at the next clock edge. If a write sets the same flag in that cycle, the flag ends up set.
- R10: A synchronous active-low reset clears every dirty flag, drops rsp_valid and zeroes the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Bus byte address |
| req_wdata | input | 32 | Write data, little-endian |
| clr_valid | input | 1 | Clear one dirty flag |
| clr_index | input | OFFSET_W-3 | Block index to clear |
| rsp_valid | output | 1 | Response for the previous request |
| rsp_region | output | 3 | Region code of the previous request |
| rsp_rdata | output | 32 | Read data, or zero after a write |
| dirty_flags | output | 2**(OFFSET_W-3) | One flag per 8-byte block |

## Verification
The bench builds the block with its default OFFSET_W of 10. That gives a 1 KiB memory and 128 dirty flags in place of the full 19-bit, 512 KiB instance. With this size, the wrap from offset 0x3FF to 0 and the aliasing of linear addresses beyond the memory size can be reached with a handful of accesses. A clear and a write can also be made to meet on the same flag. The whole dirty vector is small enough to compare against its expected value after every step.

// File: rtl/vram_pkg.sv
// Shared types and constants for the video memory access decoder.
// Assumes a 32-bit data path split into four byte lanes.
package vram_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        RG_NONE    = 3'd0,
        RG_LINEAR  = 3'd1,
        RG_PLANE   = 3'd2,
        RG_TEXT    = 3'd3,
        RG_RSVD    = 3'd4,
        RG_FONTIO  = 3'd5,
        RG_FONTROM = 3'd6
    } region_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Number of bytes touched by an access of the given size code.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    // All-ones pattern at the access width, zero-extended.
    function automatic logic [DATA_W-1:0] ones_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: ones_mask = 32'h0000_00FF;
            SZ_HALF: ones_mask = 32'h0000_FFFF;
            default: ones_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/vram_addr_decode.sv
// Address window decoder.
// Maps a bus address to a region code and a memory byte offset.
// Assumes OFFSET_W <= 20, so the linear window base has no bits in the offset.
module vram_addr_decode
    import vram_pkg::*;
#(
    parameter int OFFSET_W = 10
) (
    input  logic [31:0]         addr,
    output region_e             region,
    output logic [OFFSET_W-1:0] offset
);
    localparam logic [11:0] LINEAR_TOP = 12'h800;

    // Offset: base bits are zero below bit 20, so subtraction reduces to truncation.
    assign offset = addr[OFFSET_W-1:0];

    // Region select from the top twelve bits, then the 4 KiB page within the low megabyte.
    always_comb begin
        region = RG_NONE;
        if (addr[31:20] == LINEAR_TOP) begin
            region = RG_LINEAR;
        end else if (addr[31:20] == 12'h000) begin
            if (addr[19:15] == 5'b11000) begin
                region = RG_PLANE;
            end else begin
                case (addr[19:12])
                    8'hC8:   region = RG_TEXT;
                    8'hC9:   region = RG_RSVD;
                    8'hCA:   region = RG_FONTIO;
                    8'hCB:   region = RG_FONTROM;
                    default: region = RG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/vram_lane_map.sv
// Byte-lane mapper.
// For each of the four banks, gives the row it serves, the data byte lane
// it maps to and whether the access touches it.
// Offsets wrap modulo the memory size, so wrapped bytes use the same path.
module vram_lane_map
    import vram_pkg::*;
#(
    parameter int OFFSET_W = 10,
    localparam int ROW_W   = OFFSET_W - 2,
    localparam int BLK_W   = OFFSET_W - 3
) (
    input  logic [OFFSET_W-1:0]          offset,
    input  logic [1:0]                   size,
    output logic [LANES-1:0][ROW_W-1:0]  bank_row,
    output logic [LANES-1:0][1:0]        bank_lane,
    output logic [LANES-1:0][BLK_W-1:0]  bank_blk,
    output logic [LANES-1:0]             bank_en
);
    logic [2:0] nbytes;
    assign nbytes = size_bytes(size);

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [1:0]          lane;
        logic [OFFSET_W-1:0] byte_off;
        // Lane of this bank relative to the start of the access.
        assign lane         = 2'(b) - offset[1:0];
        // Wrapped byte offset that this bank serves.
        assign byte_off     = offset + OFFSET_W'(lane);
        assign bank_lane[b] = lane;
        assign bank_row[b]  = byte_off[OFFSET_W-1:2];
        assign bank_blk[b]  = byte_off[OFFSET_W-1:3];
        assign bank_en[b]   = ({1'b0, lane} < nbytes);
    end
endmodule

// File: rtl/vram_byte_bank.sv
// One byte-wide storage bank with change detection.
// Reads are combinational. A write updates the row only when the byte differs.
// Assumes a flop-array model; contents clear on reset.
module vram_byte_bank #(
    parameter int ROW_W = 8,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row,
    input  logic             we,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte,
    output logic             changed
);
    logic [7:0] mem [ROWS];

    // Read the addressed row.
    assign rbyte   = mem[row];
    // A write matters only if it alters the stored value.
    assign changed = we && (mem[row] != wbyte);

    // Storage update: clear on reset, else store changed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= 8'h00;
        end else if (changed) begin
            mem[row] <= wbyte;
        end
    end
endmodule

// File: rtl/vram_dirty_track.sv
// Per-block dirty flags.
// Sets come from up to four banks in a cycle; one clear per cycle.
// A set and a clear on the same flag leave it set.
module vram_dirty_track
    import vram_pkg::*;
#(
    parameter int BLK_W  = 7,
    localparam int NUM_BLK = 1 << BLK_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            set_en,
    input  logic [LANES-1:0][BLK_W-1:0] set_idx,
    input  logic                        clr_en,
    input  logic [BLK_W-1:0]            clr_idx,
    output logic [NUM_BLK-1:0]          flags
);
    logic [NUM_BLK-1:0] flags_nxt;

    // Next flags: apply the clear first so that sets override it.
    always_comb begin
        flags_nxt = flags;
        if (clr_en) flags_nxt[clr_idx] = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (set_en[k]) flags_nxt[set_idx[k]] = 1'b1;
        end
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end
endmodule

// File: rtl/vram_access_unit.sv
// Video memory access decoder, top level.
// Decodes the bus address, serves linear-window accesses from four byte
// banks with wraparound, tracks changed 8-byte blocks, and answers other
// windows with all ones. Responses are registered one cycle after the request.
module vram_access_unit
    import vram_pkg::*;
#(
    parameter int OFFSET_W = 10,
    localparam int BLK_W   = OFFSET_W - 3,
    localparam int NUM_BLK = 1 << BLK_W,
    localparam int ROW_W   = OFFSET_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_addr,
    input  logic [31:0]        req_wdata,
    input  logic               clr_valid,
    input  logic [BLK_W-1:0]   clr_index,
    output logic               rsp_valid,
    output logic [2:0]         rsp_region,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_BLK-1:0] dirty_flags
);
    region_e                     region;
    logic [OFFSET_W-1:0]         offset;
    logic [LANES-1:0][ROW_W-1:0] bank_row;
    logic [LANES-1:0][1:0]       bank_lane;
    logic [LANES-1:0][BLK_W-1:0] bank_blk;
    logic [LANES-1:0]            bank_en;
    logic [LANES-1:0][7:0]       bank_rd;
    logic [LANES-1:0]            bank_chg;
    logic                        lin_hit;
    logic [31:0]                 rd_word;

    vram_addr_decode #(.OFFSET_W(OFFSET_W)) u_dec (
        .addr   (req_addr),
        .region (region),
        .offset (offset)
    );

    vram_lane_map #(.OFFSET_W(OFFSET_W)) u_map (
        .offset    (offset),
        .size      (req_size),
        .bank_row  (bank_row),
        .bank_lane (bank_lane),
        .bank_blk  (bank_blk),
        .bank_en   (bank_en)
    );

    assign lin_hit = (region == RG_LINEAR);

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [7:0] wbyte;
        // Pick the data byte that lands in this bank.
        assign wbyte = req_wdata[8*bank_lane[b] +: 8];
        vram_byte_bank #(.ROW_W(ROW_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .row     (bank_row[b]),
            .we      (req_valid && req_write && lin_hit && bank_en[b]),
            .wbyte   (wbyte),
            .rbyte   (bank_rd[b]),
            .changed (bank_chg[b])
        );
    end

    vram_dirty_track #(.BLK_W(BLK_W)) u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (bank_chg),
        .set_idx (bank_blk),
        .clr_en  (clr_valid),
        .clr_idx (clr_index),
        .flags   (dirty_flags)
    );

    // Gather the touched bank bytes into little-endian order.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < LANES; b++) begin
            if (bank_en[b]) rd_word[8*bank_lane[b] +: 8] = bank_rd[b];
        end
    end

    // Response register: data for linear reads, all ones elsewhere, zero on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_region <= RG_NONE;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_region <= region;
                if (req_write)    rsp_rdata <= '0;
                else if (lin_hit) rsp_rdata <= rd_word;
                else              rsp_rdata <= ones_mask(req_size);
            end
        end
    end
endmodule

// File: rtl/vram_access_unit_chk.sv
// Property checker for the video memory access decoder, bound to the top.
// Assumes one cycle of response latency.
module vram_access_unit_chk
    import vram_pkg::*;
#(
    parameter int OFFSET_W = 10,
    localparam int BLK_W   = OFFSET_W - 3,
    localparam int NUM_BLK = 1 << BLK_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [1:0]         req_size,
    input logic [31:0]        req_addr,
    input logic               clr_valid,
    input logic [BLK_W-1:0]   clr_index,
    input logic               rsp_valid,
    input logic [2:0]         rsp_region,
    input logic [31:0]        rsp_rdata,
    input logic [NUM_BLK-1:0] dirty_flags
);
    logic past_ok;

    // Marks that one cycle out of reset has passed, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_rsp_tracks_req_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rsp_valid == $past(req_valid));

    p_write_rsp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rsp_valid && $past(req_write) |-> rsp_rdata == 32'h0);

    p_linear_region_r1: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(req_valid && req_addr[31:20] == 12'h800) |-> rsp_region == 3'd1);

    p_unmapped_ones_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rsp_valid && rsp_region != 3'd1 && !$past(req_write)
        |-> rsp_rdata == ones_mask($past(req_size)));

    p_ignored_write_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(req_valid && req_write && req_addr[31:20] != 12'h800 && !clr_valid)
        |-> $stable(dirty_flags));

    p_no_set_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(req_valid && req_write)
        |-> ((dirty_flags | $past(dirty_flags)) == $past(dirty_flags)));

    p_clear_takes_effect_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(clr_valid) && !$past(req_valid && req_write)
        |-> dirty_flags[$past(clr_index)] == 1'b0);
endmodule

bind vram_access_unit vram_access_unit_chk #(.OFFSET_W(OFFSET_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .clr_valid   (clr_valid),
    .clr_index   (clr_index),
    .rsp_valid   (rsp_valid),
    .rsp_region  (rsp_region),
    .rsp_rdata   (rsp_rdata),
    .dirty_flags (dirty_flags)
);

// File: tb/vram_access_unit_test.sv
`timescale 1ns/1ps
module vram_access_unit_test;
    localparam int OFFSET_W = 10;
    localparam int BLK_W    = OFFSET_W - 3;
    localparam int NUM_BLK  = 1 << BLK_W;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [2:0]  reg_code;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 32'h8000_0010, 32'h4433_2211, 32'h0000_0000, 3'd1}, // R4 write word
        '{1'b0, 2'd2, 32'h8000_0010, 32'h0,         32'h4433_2211, 3'd1}, // R4
        '{1'b0, 2'd0, 32'h8000_0012, 32'h0,         32'h0000_0033, 3'd1}, // R4 byte
        '{1'b0, 2'd1, 32'h8000_0011, 32'h0,         32'h0000_3322, 3'd1}, // R4 half
        '{1'b1, 2'd0, 32'h8000_0013, 32'h0000_00AA, 32'h0000_0000, 3'd1}, // R8 byte write
        '{1'b0, 2'd2, 32'h8000_0010, 32'h0,         32'hAA33_2211, 3'd1}, // R8
        '{1'b1, 2'd2, 32'h8000_03FE, 32'hDDCC_BBAA, 32'h0000_0000, 3'd1}, // R5 wrapped write
        '{1'b0, 2'd2, 32'h8000_03FE, 32'h0,         32'hDDCC_BBAA, 3'd1}, // R5
        '{1'b0, 2'd1, 32'h8000_03FF, 32'h0,         32'h0000_CCBB, 3'd1}, // R5 half at top
        '{1'b0, 2'd0, 32'h8000_0000, 32'h0,         32'h0000_00CC, 3'd1}, // R5
        '{1'b0, 2'd2, 32'h8000_0400, 32'h0,         32'h0000_DDCC, 3'd1}, // R1 alias
        '{1'b0, 2'd0, 32'h000C_3000, 32'h0,         32'h0000_00FF, 3'd2}, // R2 R3
        '{1'b0, 2'd1, 32'h000C_8000, 32'h0,         32'h0000_FFFF, 3'd3}, // R2 R3
        '{1'b0, 2'd2, 32'h000C_9004, 32'h0,         32'hFFFF_FFFF, 3'd4}, // R2 R3
        '{1'b0, 2'd0, 32'h000C_A000, 32'h0,         32'h0000_00FF, 3'd5}, // R2
        '{1'b0, 2'd1, 32'h000C_B010, 32'h0,         32'h0000_FFFF, 3'd6}, // R2
        '{1'b0, 2'd2, 32'h000C_C000, 32'h0,         32'hFFFF_FFFF, 3'd0}, // R2 unmapped
        '{1'b0, 2'd0, 32'h8010_0000, 32'h0,         32'h0000_00FF, 3'd0}, // R3
        '{1'b0, 2'd1, 32'h1234_5678, 32'h0,         32'h0000_FFFF, 3'd0}, // R3
        '{1'b1, 2'd2, 32'h000C_0000, 32'h1234_5678, 32'h0000_0000, 3'd2}, // R7
        '{1'b0, 2'd2, 32'h8000_0000, 32'h0,         32'h0000_DDCC, 3'd1}, // R7
        '{1'b0, 2'd3, 32'h8000_0010, 32'h0,         32'hAA33_2211, 3'd1}  // R4 size 3
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [1:0]         req_size = '0;
    logic [31:0]        req_addr = '0;
    logic [31:0]        req_wdata = '0;
    logic               clr_valid = 1'b0;
    logic [BLK_W-1:0]   clr_index = '0;
    logic               rsp_valid;
    logic [2:0]         rsp_region;
    logic [31:0]        rsp_rdata;
    logic [NUM_BLK-1:0] dirty_flags;
    logic [NUM_BLK-1:0] exp_dirty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vram_access_unit #(.OFFSET_W(OFFSET_W)) uut (
        .clk, .rst_n, .req_valid, .req_write, .req_size, .req_addr, .req_wdata,
        .clr_valid, .clr_index, .rsp_valid, .rsp_region, .rsp_rdata, .dirty_flags
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One request (optional clear alongside); outputs are valid on return.
    task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input bit clr, input logic [BLK_W-1:0] ci);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        clr_valid = clr;  clr_index = ci;
        @(negedge clk);
        req_valid = 1'b0; clr_valid = 1'b0;
    endtask

    task automatic clear_only(input logic [BLK_W-1:0] ci);
        @(negedge clk);
        clr_valid = 1'b1; clr_index = ci;
        @(negedge clk);
        clr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: state during reset
        check(rsp_valid == 1'b0, "R10 rsp_valid in reset", 128'(rsp_valid), 128'd0);
        check(dirty_flags == '0, "R10 dirty in reset", 128'(dirty_flags), 128'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wdata, 1'b0, '0);
            check(rsp_valid == 1'b1, "R6 rsp_valid", 128'(rsp_valid), 128'd1);
            check(rsp_region == VECS[i].reg_code, "R1/R2 region",
                  128'(rsp_region), 128'(VECS[i].reg_code));
            check(rsp_rdata == VECS[i].exp, "R3/R4/R5/R6 data",
                  128'(rsp_rdata), 128'(VECS[i].exp));
        end

        // R8: blocks 2, 127 and 0 were changed by the writes above
        exp_dirty = '0;
        exp_dirty[2] = 1'b1; exp_dirty[127] = 1'b1; exp_dirty[0] = 1'b1;
        check(dirty_flags == exp_dirty, "R8 dirty after writes", 128'(dirty_flags), 128'(exp_dirty));

        // R9: plain clear
        clear_only(7'd2);
        exp_dirty[2] = 1'b0;
        check(dirty_flags == exp_dirty, "R9 clear block 2", 128'(dirty_flags), 128'(exp_dirty));

        // R8: identical word rewrite sets nothing
        access(1'b1, 2'd2, 32'h8000_0010, 32'hAA33_2211, 1'b0, '0);
        check(dirty_flags == exp_dirty, "R8 same word", 128'(dirty_flags), 128'(exp_dirty));
        access(1'b1, 2'd0, 32'h8000_0011, 32'h0000_0022, 1'b0, '0);
        check(dirty_flags == exp_dirty, "R8 same byte", 128'(dirty_flags), 128'(exp_dirty));
        access(1'b1, 2'd0, 32'h8000_0011, 32'h0000_005A, 1'b0, '0);
        exp_dirty[2] = 1'b1;
        check(dirty_flags == exp_dirty, "R8 changed byte", 128'(dirty_flags), 128'(exp_dirty));
        access(1'b0, 2'd2, 32'h8000_0010, 32'h0, 1'b0, '0);
        check(rsp_rdata == 32'hAA33_5A11, "R8 stored byte", 128'(rsp_rdata), 128'h AA33_5A11);

        // R9: clear and changing write on the same block -> set wins
        clear_only(7'd2);
        access(1'b1, 2'd0, 32'h8000_0012, 32'h0000_0077, 1'b1, 7'd2);
        check(dirty_flags[2] == 1'b1, "R9 set beats clear", 128'(dirty_flags[2]), 128'd1);
        // R9: clear with an identical write on the same block -> cleared
        access(1'b1, 2'd0, 32'h8000_0012, 32'h0000_0077, 1'b1, 7'd2);
        check(dirty_flags[2] == 1'b0, "R9 clear with no-change write", 128'(dirty_flags[2]), 128'd0);
        clear_only(7'd127);
        clear_only(7'd0);
        check(dirty_flags == '0, "R9 all cleared", 128'(dirty_flags), 128'd0);

        // R7: writes outside the linear window change nothing
        access(1'b1, 2'd2, 32'h000C_0010, 32'h0102_0304, 1'b0, '0);
        check(dirty_flags == '0, "R7 planar write dirty", 128'(dirty_flags), 128'd0);
        access(1'b1, 2'd2, 32'h8010_0010, 32'h0506_0708, 1'b0, '0);
        check(dirty_flags == '0, "R7 unmapped write dirty", 128'(dirty_flags), 128'd0);
        access(1'b0, 2'd2, 32'h8000_0010, 32'h0, 1'b0, '0);
        check(rsp_rdata == 32'hAA77_5A11, "R7 memory unchanged", 128'(rsp_rdata), 128'hAA77_5A11);

        // R10: reset zeroes memory and flags
        access(1'b1, 2'd0, 32'h8000_0020, 32'h0000_0099, 1'b0, '0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 rsp_valid after reset", 128'(rsp_valid), 128'd0);
        check(dirty_flags == '0, "R10 dirty after reset", 128'(dirty_flags), 128'd0);
        rst_n = 1'b1;
        access(1'b0, 2'd2, 32'h8000_0010, 32'h0, 1'b0, '0);
        check(rsp_rdata == 32'h0, "R10 memory cleared", 128'(rsp_rdata), 128'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule